// File: doc/BRIEF.md
# Configuration Switch Override Controller

This block sits on a board-control register bus and stands between eight banks of physical DIP switches and the logic that consumes the board's configuration bytes. Each bank has a software-written shadow byte and a per-bit enable byte: wherever an enable bit is 1 the shadow bit replaces the physical switch bit, so software can change any single configuration bit without touching the hardware switches.

The block also generates the board reset. Two triggers exist. Any write to the plain reset register starts a reset that ignores the enables, so the physical switches alone are captured. A rising edge of bit 0 in the sequencer control register starts a reset that applies the overrides. In both cases the reset output stays high for a fixed, parameterized number of cycles. On release, the chosen configuration is latched onto a dedicated output for the board to sample. A separate 24-bit system-clock frequency word and its enable bit are held for an external clock synthesizer. The word is published as a whole only when its low byte is written.

Top module: `cfg_override_ctrl`

## Requirements
- R1: After power-on reset every register reads 0, and `board_rst`, `cfg_latched`, `clk_word` and `clk_ovr_en` are all 0.
- R2: Each bit of `cfg_eff` equals the shadow bit when the matching enable bit is 1. Otherwise it equals the matching `sw_phys` bit. Bank k uses bits 8k+7..8k.
- R3: Every register is 8 bits wide and reads back on `bus_rdata` in the same cycle its address is presented. Shadow bank k is at offset k (0..7) and enable bank k is at offset 8+k. The plain reset register is at 16, the sequencer control register at 17, the clock enable register at 18, and clock-word bytes 0, 1 and 2 are at 19, 20 and 21. Every other offset reads 0.
- R4: A write of any value to offset 16 raises `board_rst` at the edge that captures the write. It holds `board_rst` high for exactly RST_CYCLES clock periods.
- R5: When a reset started from offset 16 releases, `cfg_latched` takes the `sw_phys` value and ignores the enables.
- R6: A write to offset 17 with bit 0 at 1 starts a reset of RST_CYCLES periods only when the stored bit 0 was 0. At its release, `cfg_latched` takes the merged value described in R2.
- R7: A write of bit 0 = 1 to offset 17 while the stored bit 0 is already 1 starts no reset.
- R8: Reset triggers that arrive while `board_rst` is high are ignored and do not lengthen the pulse.
- R9: `clk_ovr_en` follows bit 0 of offset 18.
- R10: `clk_word` is {byte 0, byte 1, byte 2}, with byte 0 as bits 23:16. It changes only at the edge that captures a write to offset 21, and it does not change on writes to the other bytes.
- R11: A reset triggered by software does not clear the shadow, enable, control or clock registers.
- R12: `cfg_latched` changes only at the release of a software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_addr | input | ADDR_W (5) | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sw_phys | input | 8*NUM_BANKS (64) | Physical switch banks, bank k at bits 8k+7..8k |
| cfg_eff | output | 8*NUM_BANKS (64) | Live merged configuration |
| cfg_latched | output | 8*NUM_BANKS (64) | Configuration captured at reset release |
| board_rst | output | 1 | Board reset, active high |
| clk_word | output | 24 | Published system-clock frequency word |
| clk_ovr_en | output | 1 | System-clock override enable |

## Verification
Register writes take effect at the rising edge that samples `bus_wr`. Readback and `cfg_eff` are combinational, so the bench checks them half a period after that edge. `board_rst` is high from the capturing edge for RST_CYCLES periods. `cfg_latched` moves at the same edge where `board_rst` falls, and `clk_word` appears one edge after the low-byte write is presented. The bench drives and samples only on falling edges and counts the high level of `board_rst` at each falling edge, so the count equals the pulse length in periods. Checks for ignored events, such as retriggers and non-low clock bytes, observe the outputs at the falling edge right after the write and again later.

// File: rtl/cfg_ovr_pkg.sv
// Package: shared constants and types for the switch override controller.
// Assumes byte-wide registers throughout.
package cfg_ovr_pkg;
    localparam int REG_W     = 8;
    localparam int CLK_BYTES = 3;
    localparam int CLK_W     = REG_W * CLK_BYTES;
    // Number of non-bank registers: plain reset, control, clock enable, clock bytes
    localparam int MISC_REGS = 3 + CLK_BYTES;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HOLD = 1'b1
    } seq_state_e;

    typedef enum logic {
        SRC_PHYS   = 1'b0,
        SRC_MERGED = 1'b1
    } cfg_src_e;
endpackage

// File: rtl/ovr_regfile.sv
// Module: ovr_regfile
// Holds the shadow and enable bytes of every bank, the reset and control
// registers and the clock-word bytes. It provides combinational readback and
// decodes the write events that the sequencer and the clock latch use.
// Assumes a single-cycle write strobe and that bus_addr is stable while it is high.
module ovr_regfile
    import cfg_ovr_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic [REG_W-1:0]             bus_wdata,
    output logic [REG_W-1:0]             bus_rdata,
    output logic [NUM_BANKS*REG_W-1:0]   shadow_flat,
    output logic [NUM_BANKS*REG_W-1:0]   enable_flat,
    output logic [2*REG_W-1:0]           clk_hi16,
    output logic                         clk_en,
    output logic                         plain_req,
    output logic                         seq_req,
    output logic                         clk_load
);
    localparam int SH_BASE  = 0;
    localparam int EN_BASE  = NUM_BANKS;
    localparam int RST_OFS  = 2 * NUM_BANKS;
    localparam int CTRL_OFS = RST_OFS + 1;
    localparam int CKEN_OFS = RST_OFS + 2;
    localparam int CKB_OFS  = RST_OFS + 3;
    localparam int CKLO_OFS = CKB_OFS + CLK_BYTES - 1;

    logic [REG_W-1:0] shadow_q [NUM_BANKS];
    logic [REG_W-1:0] enable_q [NUM_BANKS];
    logic [REG_W-1:0] rst_q;
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] cken_q;
    logic [REG_W-1:0] ckb_q [CLK_BYTES];

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            // Purpose: capture the shadow byte of this bank.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    shadow_q[gb] <= '0;
                else if (bus_wr && bus_addr == ADDR_W'(SH_BASE + gb))
                    shadow_q[gb] <= bus_wdata;
            end

            // Purpose: capture the override-enable byte of this bank.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    enable_q[gb] <= '0;
                else if (bus_wr && bus_addr == ADDR_W'(EN_BASE + gb))
                    enable_q[gb] <= bus_wdata;
            end

            assign shadow_flat[gb*REG_W +: REG_W] = shadow_q[gb];
            assign enable_flat[gb*REG_W +: REG_W] = enable_q[gb];
        end
    endgenerate

    // Purpose: capture the reset, control and clock-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q  <= '0;
            ctrl_q <= '0;
            cken_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(RST_OFS))  rst_q  <= bus_wdata;
            if (bus_addr == ADDR_W'(CTRL_OFS)) ctrl_q <= bus_wdata;
            if (bus_addr == ADDR_W'(CKEN_OFS)) cken_q <= bus_wdata;
        end
    end

    // Purpose: capture the clock-word byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < CLK_BYTES; k++) ckb_q[k] <= '0;
        end else if (bus_wr) begin
            for (int k = 0; k < CLK_BYTES; k++)
                if (bus_addr == ADDR_W'(CKB_OFS + k)) ckb_q[k] <= bus_wdata;
        end
    end

    // Purpose: select the read data for the presented offset; unmapped reads 0.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bus_addr == ADDR_W'(SH_BASE + i)) bus_rdata = shadow_q[i];
            if (bus_addr == ADDR_W'(EN_BASE + i)) bus_rdata = enable_q[i];
        end
        if (bus_addr == ADDR_W'(RST_OFS))  bus_rdata = rst_q;
        if (bus_addr == ADDR_W'(CTRL_OFS)) bus_rdata = ctrl_q;
        if (bus_addr == ADDR_W'(CKEN_OFS)) bus_rdata = cken_q;
        for (int k = 0; k < CLK_BYTES; k++)
            if (bus_addr == ADDR_W'(CKB_OFS + k)) bus_rdata = ckb_q[k];
    end

    // Write events: any plain-reset write, and a 0-to-1 change of control bit 0.
    assign plain_req = bus_wr && (bus_addr == ADDR_W'(RST_OFS));
    assign seq_req   = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS))
                       && bus_wdata[0] && !ctrl_q[0];
    assign clk_load  = bus_wr && (bus_addr == ADDR_W'(CKLO_OFS));
    assign clk_hi16  = {ckb_q[0], ckb_q[1]};
    assign clk_en    = cken_q[0];
endmodule

// File: rtl/ovr_merge.sv
// Module: ovr_merge
// Per-bit selection between the physical switch and the shadow bit, driven by
// the enable bit. It is purely combinational and assumes flat bank-major vectors.
module ovr_merge
    import cfg_ovr_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic [NUM_BANKS*REG_W-1:0] phys,
    input  logic [NUM_BANKS*REG_W-1:0] shadow,
    input  logic [NUM_BANKS*REG_W-1:0] enable,
    output logic [NUM_BANKS*REG_W-1:0] merged
);
    genvar gb, gi;
    generate
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            for (gi = 0; gi < REG_W; gi++) begin : g_bit
                localparam int IDX = gb * REG_W + gi;
                assign merged[IDX] = enable[IDX] ? shadow[IDX] : phys[IDX];
            end
        end
    endgenerate
endmodule

// File: rtl/ovr_rst_seq.sv
// Module: ovr_rst_seq
// Reset sequencer. It accepts a plain or an override-honouring trigger while idle,
// holds the board reset for RST_CYCLES periods, and at release latches either
// the physical or the merged configuration. Triggers during a pulse are dropped.
// Assumes RST_CYCLES >= 1.
module ovr_rst_seq
    import cfg_ovr_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int RST_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              plain_req,
    input  logic              seq_req,
    input  logic [DATA_W-1:0] cfg_phys,
    input  logic [DATA_W-1:0] cfg_merged,
    output logic              board_rst,
    output logic [DATA_W-1:0] cfg_latched
);
    localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    seq_state_e       state_q;
    cfg_src_e         src_q;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: run the idle/hold state machine and latch configuration at release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            src_q       <= SRC_PHYS;
            cnt_q       <= '0;
            cfg_latched <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    cnt_q <= '0;
                    if (plain_req) begin
                        state_q <= SEQ_HOLD;
                        src_q   <= SRC_PHYS;
                    end else if (seq_req) begin
                        state_q <= SEQ_HOLD;
                        src_q   <= SRC_MERGED;
                    end
                end
                SEQ_HOLD: begin
                    if (cnt_q == CNT_LAST) begin
                        state_q     <= SEQ_IDLE;
                        cnt_q       <= '0;
                        cfg_latched <= (src_q == SRC_MERGED) ? cfg_merged : cfg_phys;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign board_rst = (state_q == SEQ_HOLD);
endmodule

// File: rtl/ovr_clkword.sv
// Module: ovr_clkword
// Publishes the 24-bit clock word in one step when its low byte is written,
// so a partly updated word never reaches the output.
module ovr_clkword
    import cfg_ovr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_load,
    input  logic [2*REG_W-1:0] clk_hi16,
    input  logic [REG_W-1:0]   low_byte,
    output logic [CLK_W-1:0]   clk_word
);
    // Purpose: load the assembled word on a low-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_word <= '0;
        else if (clk_load)
            clk_word <= {clk_hi16, low_byte};
    end
endmodule

// File: rtl/cfg_override_ctrl.sv
// Module: cfg_override_ctrl (top)
// Switch override controller. It connects the register file, the per-bit merge,
// the reset sequencer and the clock-word latch. Assumes a synchronous byte-wide
// bus with one-cycle write strobes.
module cfg_override_ctrl
    import cfg_ovr_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int RST_CYCLES = 64,
    parameter int ADDR_W     = $clog2(2 * NUM_BANKS + MISC_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [REG_W-1:0]           bus_wdata,
    output logic [REG_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*REG_W-1:0] sw_phys,
    output logic [NUM_BANKS*REG_W-1:0] cfg_eff,
    output logic [NUM_BANKS*REG_W-1:0] cfg_latched,
    output logic                       board_rst,
    output logic [CLK_W-1:0]           clk_word,
    output logic                       clk_ovr_en
);
    localparam int DATA_W = NUM_BANKS * REG_W;

    logic [DATA_W-1:0]  shadow_flat;
    logic [DATA_W-1:0]  enable_flat;
    logic [2*REG_W-1:0] clk_hi16;
    logic               plain_req;
    logic               seq_req;
    logic               clk_load;

    ovr_regfile #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .shadow_flat (shadow_flat),
        .enable_flat (enable_flat),
        .clk_hi16    (clk_hi16),
        .clk_en      (clk_ovr_en),
        .plain_req   (plain_req),
        .seq_req     (seq_req),
        .clk_load    (clk_load)
    );

    ovr_merge #(
        .NUM_BANKS (NUM_BANKS)
    ) u_merge (
        .phys   (sw_phys),
        .shadow (shadow_flat),
        .enable (enable_flat),
        .merged (cfg_eff)
    );

    ovr_rst_seq #(
        .DATA_W     (DATA_W),
        .RST_CYCLES (RST_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .plain_req   (plain_req),
        .seq_req     (seq_req),
        .cfg_phys    (sw_phys),
        .cfg_merged  (cfg_eff),
        .board_rst   (board_rst),
        .cfg_latched (cfg_latched)
    );

    ovr_clkword u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_load (clk_load),
        .clk_hi16 (clk_hi16),
        .low_byte (bus_wdata),
        .clk_word (clk_word)
    );
endmodule

// File: rtl/cfg_ovr_chk.sv
// Module: cfg_ovr_chk
// Assertion checker bound to cfg_override_ctrl. It observes only the top-level ports.
module cfg_ovr_chk
    import cfg_ovr_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int RST_CYCLES = 64,
    parameter int ADDR_W     = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_wr,
    input logic [REG_W-1:0]           bus_wdata,
    input logic                       board_rst,
    input logic [NUM_BANKS*REG_W-1:0] cfg_latched,
    input logic [CLK_W-1:0]           clk_word
);
    localparam logic [ADDR_W-1:0] LOW_OFS = ADDR_W'(2 * NUM_BANKS + 3 + CLK_BYTES - 1);

    int hi_cnt;
    logic low_wr;
    assign low_wr = bus_wr && (bus_addr == LOW_OFS);

    // Purpose: count consecutive sampled-high cycles of board_rst.
    always_ff @(posedge clk) begin
        if (!rst_n)         hi_cnt <= 0;
        else if (board_rst) hi_cnt <= hi_cnt + 1;
        else                hi_cnt <= 0;
    end

    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(board_rst) |-> hi_cnt == RST_CYCLES);                       // R4
    AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(board_rst) |-> $past(bus_wr));                                // R6
    AST_LATCH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!board_rst && !$past(board_rst)) |-> $stable(cfg_latched));        // R12
    AST_CLKWORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        low_wr |=> clk_word[REG_W-1:0] == $past(bus_wdata));                // R10
    AST_CLKWORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !low_wr |=> $stable(clk_word));                                     // R10
endmodule

bind cfg_override_ctrl cfg_ovr_chk #(
    .NUM_BANKS  (NUM_BANKS),
    .RST_CYCLES (RST_CYCLES),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .board_rst   (board_rst),
    .cfg_latched (cfg_latched),
    .clk_word    (clk_word)
);

// File: tb/tb_cfg_override_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_override_ctrl;
    localparam int NB  = 8;
    localparam int RC  = 12;
    localparam int AW  = 5;
    localparam int DW  = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [DW-1:0] sw_phys = '0;
    logic [DW-1:0] cfg_eff;
    logic [DW-1:0] cfg_latched;
    logic          board_rst;
    logic [23:0]   clk_word;
    logic          clk_ovr_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] sh_m [NB];
    logic [7:0] en_m [NB];

    always #2 clk = ~clk;

    cfg_override_ctrl #(.NUM_BANKS(NB), .RST_CYCLES(RC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_phys(sw_phys),
        .cfg_eff(cfg_eff), .cfg_latched(cfg_latched), .board_rst(board_rst),
        .clk_word(clk_word), .clk_ovr_en(clk_ovr_en)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    // Counts falling edges with board_rst high, starting at the current one.
    task automatic wait_release(output int n);
        n = 0;
        while (board_rst === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [DW-1:0] merged_model(input logic [DW-1:0] p);
        logic [DW-1:0] m;
        for (int b = 0; b < NB; b++)
            m[b*8 +: 8] = (sh_m[b] & en_m[b]) | (p[b*8 +: 8] & ~en_m[b]);
        return m;
    endfunction

    task automatic t_reset_state();
        logic [7:0] d;
        check("R1 board_rst", 64'(board_rst), 64'd0);
        check("R1 cfg_latched", cfg_latched, 64'd0);
        check("R1 clk_word", 64'(clk_word), 64'd0);
        check("R1 clk_ovr_en", 64'(clk_ovr_en), 64'd0);
        for (int a = 0; a < 22; a++) begin
            rd(a, d);
            check($sformatf("R1 reg %0d", a), 64'(d), 64'd0);
        end
    endtask

    task automatic t_readback();
        logic [7:0] d;
        for (int b = 0; b < NB; b++) begin
            sh_m[b] = 8'hA0 + 8'(b); en_m[b] = 8'h30 + 8'(b);
            wr(b, sh_m[b]); wr(8 + b, en_m[b]);
        end
        wr(17, 8'hFE);
        for (int b = 0; b < NB; b++) begin
            rd(b, d);     check($sformatf("R3 shadow %0d", b), 64'(d), 64'(sh_m[b]));
            rd(8 + b, d); check($sformatf("R3 enable %0d", b), 64'(d), 64'(en_m[b]));
        end
        rd(17, d); check("R3 ctrl readback", 64'(d), 64'hFE);
        check("R7 even bit0=0 write no reset", 64'(board_rst), 64'd0);
        for (int a = 22; a < 32; a++) begin
            rd(a, d); check($sformatf("R3 unmapped %0d", a), 64'(d), 64'd0);
        end
    endtask

    task automatic t_merge();
        sw_phys = 64'h0123_4567_89AB_CDEF;
        #1 check("R2 merge pattern A", cfg_eff, merged_model(sw_phys));
        sw_phys = 64'hFFFF_0000_F0F0_5A5A;
        #1 check("R2 merge pattern B", cfg_eff, merged_model(sw_phys));
        sh_m[3] = 8'h00; en_m[3] = 8'hFF;
        wr(3, sh_m[3]); wr(11, en_m[3]);
        check("R2 full-override bank3", 64'(cfg_eff[31:24]), 64'h00);
    endtask

    task automatic t_clock();
        logic [7:0] d;
        wr(18, 8'h01); check("R9 enable set", 64'(clk_ovr_en), 64'd1);
        wr(18, 8'h02); check("R9 bit1 only clears", 64'(clk_ovr_en), 64'd0);
        rd(18, d);     check("R3 clken readback", 64'(d), 64'h02);
        wr(19, 8'h12); check("R10 byte0 not published", 64'(clk_word), 64'd0);
        wr(20, 8'h34); check("R10 byte1 not published", 64'(clk_word), 64'd0);
        wr(21, 8'h56); check("R10 word after low byte", 64'(clk_word), 64'h123456);
        wr(19, 8'hAB); check("R10 held after byte0 change", 64'(clk_word), 64'h123456);
        rd(19, d);     check("R3 clkbyte0 readback", 64'(d), 64'hAB);
        rd(21, d);     check("R3 clkbyte2 readback", 64'(d), 64'h56);
    endtask

    task automatic t_plain_reset();
        int n;
        logic [7:0] d;
        sw_phys = 64'hC3C3_1111_2222_0F0F;
        wr(16, 8'h5A);
        check("R4 rst high after write", 64'(board_rst), 64'd1);
        wait_release(n);
        check("R4 pulse length", 64'(n), 64'(RC));
        check("R5 latched physical", cfg_latched, sw_phys);
        rd(16, d); check("R3 rst readback", 64'(d), 64'h5A);
        rd(5, d);  check("R11 shadow kept", 64'(d), 64'(sh_m[5]));
        rd(13, d); check("R11 enable kept", 64'(d), 64'(en_m[5]));
        check("R11 clk word kept", 64'(clk_word), 64'h123456);
    endtask

    task automatic t_seq_reset();
        int n;
        logic [DW-1:0] exp;
        sw_phys = 64'h0F0F_F0F0_AAAA_5555;
        exp = merged_model(sw_phys);
        wr(17, 8'h01);
        check("R6 rst high after rising ctrl", 64'(board_rst), 64'd1);
        wait_release(n);
        check("R6 pulse length", 64'(n), 64'(RC));
        check("R6 latched merged", cfg_latched, exp);
        wr(17, 8'h01);
        check("R7 no retrigger", 64'(board_rst), 64'd0);
        repeat (3) @(negedge clk);
        check("R7 still idle", 64'(board_rst), 64'd0);
        wr(17, 8'h00);
        wr(17, 8'h01);
        wait_release(n);
        check("R6 re-arm after 0", 64'(n), 64'(RC));
    endtask

    task automatic t_busy_and_steady();
        int n;
        logic [DW-1:0] phys_at;
        sw_phys = 64'h1357_9BDF_2468_ACE0;
        phys_at = sw_phys;
        wr(16, 8'h00);
        wr(17, 8'h00);
        wr(17, 8'h01);
        wr(16, 8'h01);
        wait_release(n);
        check("R8 pulse not lengthened", 64'(n), 64'(RC - 6));
        check("R8 plain source kept", cfg_latched, phys_at);
        repeat (4) @(negedge clk);
        check("R8 dropped trigger", 64'(board_rst), 64'd0);
        sw_phys = ~sw_phys;
        wr(2, 8'h77); wr(10, 8'hFF);
        repeat (2) @(negedge clk);
        check("R12 latched steady", cfg_latched, phys_at);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_readback();
        t_merge();
        t_clock();
        t_plain_reset();
        t_seq_reset();
        t_busy_and_steady();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule